// File: doc/BRIEF.md
# UART Register Bank with Divisor Latches

This block is the processor-facing register front end of a 16550-style UART. A simple synchronous register bus (word address, write strobe, read strobe, write data, read data and a ready handshake) reaches the transmit holding register, the receive buffer, the interrupt enable and line control registers, a FIFO control bit, the line status register and a pair of byte-wide divisor latches. The two divisor bytes together form a 16-bit baud divisor. A down counter turns that divisor into a one-cycle baud tick.

Two addresses are shared. The divisor access bit in the line control register decides whether each shared address reaches a divisor byte or its normal register. Both divisor bytes can also be reached at their own addresses regardless of that bit, so software can leave the access bit clear. Each divisor write holds the bus for two wait states while the baud counter is reloaded. Received characters arrive on a push port and go into a small receive store. The store acts as a single holding register or as a 16-entry FIFO, and it drives the data-ready status bit and the receive interrupt.

Register word addresses: 0 is the shared receive/transmit/divisor-low address, 1 is the shared interrupt-enable/divisor-high address, 2 is FIFO control, 3 is line control, 5 is line status, 8 is the dedicated divisor low byte and 9 is the dedicated divisor high byte. Reads of any other address return 0.

Top module: `uart_regbank`

## Requirements
- R1: After reset the divisor (both bytes), interrupt enable, line control, FIFO control and line status all read 0, irq is 0, and bus_ready is 1 while no access is pending.
- R2: At address 0 with line-control bit 7 set, reads and writes reach the divisor low byte. With that bit clear, a read returns the receive buffer, and a write drives thr_data and pulses thr_load for one cycle after the accepting edge, leaving the divisor unchanged.
- R3: At address 1 with line-control bit 7 set, reads and writes reach the divisor high byte. With it clear, they reach the interrupt enable register and the divisor is unchanged.
- R4: Addresses 8 and 9 reach the divisor low and high bytes whatever the value of line-control bit 7.
- R5: Every write that reaches a divisor byte, through a shared or a dedicated address, holds bus_ready low for exactly two cycles before it is accepted. Every other access is accepted with no wait state.
- R6: With a nonzero divisor D, baud_tick pulses for one cycle every D cycles. With a divisor of 0, baud_tick stays low.
- R7: With FIFO control bit 0 clear, the receive store holds one character. Line-status bit 0 (data ready) sets when a character is pushed and clears when it is read at address 0. A push while a character is held replaces that character.
- R8: With FIFO control bit 0 set, the receive store is a 16-entry FIFO read in push order. Data ready sets on the first push and stays set until the last entry is read. A push to a full FIFO is dropped.
- R9: irq is 1 exactly when data ready is set and interrupt-enable bit 0 is 1.
- R10: A receive-buffer read with the store empty returns the last character read. A write to FIFO control that changes bit 0 empties the receive store.
- R11: Line control reads back at address 3 as written. Line status at address 5 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, held until bus_ready |
| bus_rd | input | 1 | Read strobe, held until bus_ready |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the accepting cycle |
| bus_ready | output | 1 | Access accepted at the next edge when high |
| rx_push | input | 1 | One-cycle push of a received character |
| rx_data | input | 8 | Received character |
| thr_data | output | 8 | Last value written to the transmit holding register |
| thr_load | output | 1 | One-cycle pulse after a transmit holding write |
| baud_tick | output | 1 | One-cycle baud tick |
| irq | output | 1 | Receive data interrupt request |

## Verification
The assertions assume that the bus master never raises write and read together and holds address, strobe and data steady until bus_ready is seen high. Under those conditions the wait-state bound and the rule that the divisor only changes on an accepted write are meaningful. The data-ready checks assume that rx_push is a single-cycle strobe. The bench drives every access through one task that keeps all bus inputs constant until acceptance and drops the strobe right after the accepting edge. Pushes are issued only between bus accesses, and the bench always leaves at least one idle cycle between them.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam int A_SHARED_LO = 0;
  localparam int A_SHARED_HI = 1;
  localparam int A_FIFO_CTL  = 2;
  localparam int A_LINE_CTL  = 3;
  localparam int A_LINE_STAT = 5;
  localparam int A_DIV_LO    = 8;
  localparam int A_DIV_HI    = 9;

  localparam int DLAB_BIT = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXTX,
    SEL_IEN,
    SEL_FCTL,
    SEL_LCTL,
    SEL_LSTAT,
    SEL_DIVLO,
    SEL_DIVHI
  } reg_sel_t;
endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uart_baud_counter.sv
module uart_baud_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (reload) begin
      cnt_d = divisor;
    end else if (divisor == '0) begin
      cnt_d = '0;
    end else if (cnt_q <= DIV_W'(1)) begin
      cnt_d  = divisor;
      tick_d = (cnt_q == DIV_W'(1));
    end else begin
      cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  assert_no_tick_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ($past(divisor) != '0));
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              single_mode,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop, do_push, do_over, full;
  logic [PTR_W-1:0]  wr_idx;

  assign empty   = (cnt_q == '0);
  assign full    = single_mode ? (cnt_q != '0) : (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && !flush && (!full || (single_mode && do_pop));
  assign do_over = push && !flush && single_mode && full && !do_pop;
  assign wr_idx  = do_over ? rd_ptr_q : wr_ptr_q;
  assign head    = mem[rd_ptr_q];

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_pop) begin
        rd_ptr_d = rd_ptr_q + PTR_W'(1);
        cnt_d    = cnt_d - CNT_W'(1);
      end
      if (do_push) begin
        wr_ptr_d = wr_ptr_q + PTR_W'(1);
        cnt_d    = cnt_d + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push || do_over) mem[wr_idx] <= push_data;
  end

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_single_holds_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(single_mode) && single_mode && !$past(flush)) |-> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] thr_data,
  output logic              thr_load,
  output logic              baud_tick,
  output logic              irq
);
  localparam int DIV_W = 2 * DATA_W;

  logic              rst_ns;
  reg_sel_t          sel;
  logic              dlab;
  logic              div_sel, div_wr_pend, wr_acc, rd_acc, div_commit;
  logic              ws_first_q, ws_first_d, ws_done_q, ws_done_d;
  logic [DATA_W-1:0] dll_q, dll_d, dlh_q, dlh_d, ier_q, ier_d, lcr_q, lcr_d;
  logic [DATA_W-1:0] thr_q, thr_d, last_q, last_d;
  logic              fen_q, fen_d, thr_ld_q, thr_ld_d, reload_q;
  logic              flush, pop, rx_empty, dr;
  logic [DATA_W-1:0] rx_head, rbr_val;

  uart_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a, input logic dl);
    case (int'(a))
      A_SHARED_LO: decode = dl ? SEL_DIVLO : SEL_RXTX;
      A_SHARED_HI: decode = dl ? SEL_DIVHI : SEL_IEN;
      A_FIFO_CTL:  decode = SEL_FCTL;
      A_LINE_CTL:  decode = SEL_LCTL;
      A_LINE_STAT: decode = SEL_LSTAT;
      A_DIV_LO:    decode = SEL_DIVLO;
      A_DIV_HI:    decode = SEL_DIVHI;
      default:     decode = SEL_NONE;
    endcase
  endfunction

  assign dlab        = lcr_q[DLAB_BIT];
  assign sel         = decode(bus_addr, dlab);
  assign div_sel     = (sel == SEL_DIVLO) || (sel == SEL_DIVHI);
  assign div_wr_pend = bus_wr && div_sel && !ws_done_q;
  assign bus_ready   = !div_wr_pend;
  assign wr_acc      = bus_wr && bus_ready;
  assign rd_acc      = bus_rd && bus_ready;
  assign div_commit  = wr_acc && div_sel;

  // wait-state sequencer: two held cycles, then acceptance
  always_comb begin
    ws_first_d = ws_first_q;
    ws_done_d  = 1'b0;
    if (div_wr_pend) begin
      if (!ws_first_q) begin
        ws_first_d = 1'b1;
      end else begin
        ws_first_d = 1'b0;
        ws_done_d  = 1'b1;
      end
    end
  end

  // register next-state
  always_comb begin
    dll_d    = dll_q;
    dlh_d    = dlh_q;
    ier_d    = ier_q;
    lcr_d    = lcr_q;
    thr_d    = thr_q;
    fen_d    = fen_q;
    thr_ld_d = 1'b0;
    if (wr_acc) begin
      case (sel)
        SEL_DIVLO: dll_d = bus_wdata;
        SEL_DIVHI: dlh_d = bus_wdata;
        SEL_IEN:   ier_d = bus_wdata;
        SEL_LCTL:  lcr_d = bus_wdata;
        SEL_FCTL:  fen_d = bus_wdata[0];
        SEL_RXTX: begin
          thr_d    = bus_wdata;
          thr_ld_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign flush   = wr_acc && (sel == SEL_FCTL) && (bus_wdata[0] != fen_q);
  assign pop     = rd_acc && (sel == SEL_RXTX);
  assign rbr_val = rx_empty ? last_q : rx_head;
  assign last_d  = (pop && !rx_empty) ? rx_head : last_q;
  assign dr      = !rx_empty;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ws_first_q <= 1'b0;
      ws_done_q  <= 1'b0;
      dll_q      <= '0;
      dlh_q      <= '0;
      ier_q      <= '0;
      lcr_q      <= '0;
      thr_q      <= '0;
      fen_q      <= 1'b0;
      thr_ld_q   <= 1'b0;
      reload_q   <= 1'b0;
      last_q     <= '0;
    end else begin
      ws_first_q <= ws_first_d;
      ws_done_q  <= ws_done_d;
      dll_q      <= dll_d;
      dlh_q      <= dlh_d;
      ier_q      <= ier_d;
      lcr_q      <= lcr_d;
      thr_q      <= thr_d;
      fen_q      <= fen_d;
      thr_ld_q   <= thr_ld_d;
      reload_q   <= div_commit;
      last_q     <= last_d;
    end
  end

  uart_rx_store #(.DEPTH(RX_DEPTH), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_ns), .flush(flush), .single_mode(!fen_q),
    .push(rx_push), .push_data(rx_data), .pop(pop),
    .head(rx_head), .empty(rx_empty)
  );

  uart_baud_counter #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_ns), .divisor({dlh_q, dll_q}),
    .reload(reload_q), .tick(baud_tick)
  );

  always_comb begin
    case (sel)
      SEL_RXTX:  bus_rdata = rbr_val;
      SEL_IEN:   bus_rdata = ier_q;
      SEL_FCTL:  bus_rdata = {{(DATA_W-1){1'b0}}, fen_q};
      SEL_LCTL:  bus_rdata = lcr_q;
      SEL_LSTAT: bus_rdata = {{(DATA_W-1){1'b0}}, dr};
      SEL_DIVLO: bus_rdata = dll_q;
      SEL_DIVHI: bus_rdata = dlh_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign thr_data = thr_q;
  assign thr_load = thr_ld_q;
  assign irq      = ier_q[0] && dr;

  assert_two_waits_max_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (!bus_ready && $past(!bus_ready)) |=> bus_ready);
  assert_div_changes_on_write_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable({dlh_q, dll_q}) |-> $past(bus_wr && bus_ready && div_sel));
  assert_dr_rises_on_push_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(dr) |-> $past(rx_push));
  assert_dr_falls_on_read_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(dr) |-> $past(pop || flush));
  assert_thr_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    thr_load |=> !thr_load);
endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ready;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] thr_data;
  logic       thr_load, baud_tick, irq;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .rx_push(rx_push), .rx_data(rx_data), .thr_data(thr_data), .thr_load(thr_load),
    .baud_tick(baud_tick), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted read
  always @(negedge clk) begin
    if (bus_rd && bus_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected read: actual %0h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, bus_rdata, e.val);
      end
    end
  end

  task automatic bus_write(input int a, input int d, output int waits);
    waits = 0;
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    forever begin
      @(negedge clk);
      if (bus_ready) break;
      waits++;
    end
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    int w;
    bus_write(a, d, w);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    exp_t e;
    e.val = 8'(exp); e.tag = tag;
    exp_q.push_back(e);
    bus_addr = 4'(a); bus_rd = 1'b1;
    forever begin
      @(negedge clk);
      if (bus_ready) break;
    end
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic push(input int d);
    rx_data = 8'(d); rx_push = 1'b1;
    @(posedge clk); #1;
    rx_push = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w, t0, t1, nt;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 ready", bus_ready, 1);
    check("R1 irq", irq, 0);
    rd(3, 8'h00, "R1 lcr");
    rd(5, 8'h00, "R1 lsr");
    rd(1, 8'h00, "R1 ier");
    rd(2, 8'h00, "R1 fctl");
    rd(8, 8'h00, "R1 div lo");
    rd(9, 8'h00, "R1 div hi");

    // R4/R5 dedicated divisor writes
    bus_write(8, 8'h34, w); check("R5 dedicated lo waits", w, 2);
    bus_write(9, 8'h12, w); check("R5 dedicated hi waits", w, 2);
    rd(8, 8'h34, "R4 dedicated lo");
    rd(9, 8'h12, "R4 dedicated hi");

    // R11 line control / status
    bus_write(3, 8'h83, w); check("R5 lcr no wait", w, 0);
    rd(3, 8'h83, "R11 lcr readback");
    wr(5, 8'hFF);
    rd(5, 8'h00, "R11 lsr ignores write");

    // R2/R3 with DLAB set
    bus_write(0, 8'h56, w); check("R5 shared lo waits", w, 2);
    bus_write(1, 8'h78, w); check("R5 shared hi waits", w, 2);
    rd(0, 8'h56, "R2 dlab lo read");
    rd(1, 8'h78, "R3 dlab hi read");
    rd(8, 8'h56, "R4 lo via dedicated");
    rd(9, 8'h78, "R4 hi via dedicated");
    check("R2 no thr load under dlab", thr_load, 0);

    // R2/R3 with DLAB clear
    wr(3, 8'h03);
    bus_write(0, 8'h5A, w);
    check("R5 thr no wait", w, 0);
    check("R2 thr_load", thr_load, 1);
    check("R2 thr_data", thr_data, 8'h5A);
    idle(1);
    check("R2 thr_load one cycle", thr_load, 0);
    rd(8, 8'h56, "R2 div lo untouched");
    bus_write(1, 8'h00, w); check("R5 ier no wait", w, 0);
    rd(1, 8'h00, "R3 ier read");
    rd(9, 8'h78, "R3 div hi untouched");
    bus_write(8, 8'h9C, w); check("R4 dedicated with dlab 0 waits", w, 2);
    rd(8, 8'h9C, "R4 dedicated lo dlab 0");

    // R6 baud ticks
    wr(9, 0); wr(8, 5);
    idle(20);
    while (!baud_tick) idle(1);
    t0 = cyc;
    idle(1);
    while (!baud_tick) idle(1);
    t1 = cyc;
    check("R6 period 5", t1 - t0, 5);
    wr(8, 1);
    idle(4);
    nt = 0;
    for (int i = 0; i < 10; i++) begin if (baud_tick) nt++; idle(1); end
    check("R6 divisor 1 every cycle", nt, 10);
    wr(8, 0);
    idle(3);
    nt = 0;
    for (int i = 0; i < 40; i++) begin if (baud_tick) nt++; idle(1); end
    check("R6 no tick at zero", nt, 0);

    // R7 / R9 non-FIFO mode
    wr(1, 1);
    check("R9 irq idle", irq, 0);
    push(8'hA1); idle(1);
    check("R9 irq with data", irq, 1);
    rd(5, 8'h01, "R7 dr set");
    rd(0, 8'hA1, "R7 rbr read");
    rd(5, 8'h00, "R7 dr cleared");
    check("R9 irq cleared", irq, 0);
    push(8'hA2); idle(1);
    push(8'hA3); idle(1);
    rd(0, 8'hA3, "R7 overwrite");
    rd(5, 8'h00, "R7 single entry");
    rd(0, 8'hA3, "R10 empty read repeats last");
    push(8'hA4); idle(1);
    wr(1, 0);
    check("R9 irq masked", irq, 0);
    rd(0, 8'hA4, "R7 drain");

    // R8 FIFO mode
    wr(2, 1);
    rd(2, 8'h01, "R8 fifo enable readback");
    wr(1, 1);
    for (int i = 0; i < 17; i++) begin push(8'h10 + i); idle(1); end
    check("R9 irq fifo", irq, 1);
    for (int i = 0; i < 16; i++) begin
      rd(0, 8'h10 + i, "R8 fifo order");
      if (i == 14) rd(5, 8'h01, "R8 dr held");
    end
    rd(5, 8'h00, "R8 dr after drain");
    check("R9 irq after drain", irq, 0);
    rd(0, 8'h1F, "R10 last read after drain (R8 drop)");

    // R10 flush on mode change
    push(8'h77); idle(1);
    rd(5, 8'h01, "R10 data before flush");
    wr(2, 0);
    rd(5, 8'h00, "R10 flushed");
    check("R10 irq after flush", irq, 0);

    idle(3);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule